// File: doc/BRIEF.md
# Converter Result Register Pair with Coherent Read Lock

This block keeps the most recent 10-bit conversion result from an analog-to-digital converter and shows it to software as two byte-wide read registers, a low byte and a high byte. A one-cycle completion pulse from the converter carries the new result. The result is stored unformatted. An adjust select chooses at read time whether the value is right aligned or left aligned across the two bytes. With left alignment, software can read only the high byte and get an 8-bit result.

Software that needs the full result reads the low byte first and the high byte second. The low-byte read strobe freezes the stored value. The high-byte read strobe releases it. A conversion that finishes while the value is frozen is thrown away, so the two bytes always come from the same conversion. A sticky completion flag is set by every finished conversion, including one that was thrown away. The interrupt request is that flag gated by an enable. Software clears the flag by pulsing a clear input.

Top module: `adc_result_lock`

## Requirements
- R1: One cycle after a cycle with `convDone` high and no lock in force, the read bytes reflect the `convData` value from that cycle.
- R2: With `leftAdjust` low, `highData` is {6'b0, result[9:8]} and `lowData` is result[7:0].
- R3: With `leftAdjust` high, `highData` is result[9:2] and `lowData` is {result[1:0], 6'b0}. A change of `leftAdjust` changes the read bytes in the same cycle, without a new conversion.
- R4: A cycle with `rdLowStb` high blocks the capture of a conversion in that same cycle. It also sets a lock that blocks every later capture until the lock is released, so both bytes keep their value.
- R5: A cycle with `rdHighStb` high releases the lock. A conversion in that same cycle, while the lock is still set, is dropped. A conversion in a later cycle is captured.
- R6: A high-byte read without a prior low-byte read has no effect: the lock stays released, and the next conversion is captured.
- R7: Every `convDone` pulse, whether it was captured or dropped, sets the completion flag one cycle later. The flag stays set until it is cleared.
- R8: `irqClear` clears the flag one cycle later. When `convDone` and `irqClear` are high in the same cycle, the flag ends up set.
- R9: `irqReq` is high exactly when the flag is set and `irqEnable` is high. Setting `irqEnable` while the flag is already set raises `irqReq` in the same cycle.
- R10: After reset both read bytes are zero, the flag is clear and the lock is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| convDone | input | 1 | One-cycle pulse: a conversion has finished |
| convData | input | 10 | Conversion result, valid while convDone is high |
| rdLowStb | input | 1 | Software read strobe for the low byte |
| rdHighStb | input | 1 | Software read strobe for the high byte |
| leftAdjust | input | 1 | 1 = left aligned, 0 = right aligned |
| irqEnable | input | 1 | Interrupt enable |
| irqClear | input | 1 | Pulse that clears the completion flag |
| lowData | output | 8 | Low byte read data |
| highData | output | 8 | High byte read data |
| irqReq | output | 1 | Interrupt request |

## Verification
Captured results, the lock state and the completion flag each take effect at the first rising edge after their strobe. They are therefore due one cycle after the stimulus. The alignment select and the interrupt enable act through combinational logic and take effect in the same cycle. The bench changes inputs on the falling edge and checks registered results on the next falling edge, half a cycle after the capturing edge. It checks combinational results a short delay after the input change. The same-cycle cases are tested by raising two strobes on one falling edge: low read with conversion, high read with conversion, and clear with conversion.

// File: rtl/adc_lock_pkg.sv
package adc_lock_pkg;
  localparam int unsigned DEF_RES_W  = 10;
  localparam int unsigned DEF_BYTE_W = 8;

  typedef struct packed {
    logic capture;
    logic setFlag;
    logic clrFlag;
  } ctlStrobes_t;
endpackage

// File: rtl/adc_lock_ctl.sv
module adc_lock_ctl
  import adc_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        convDone,
  input  logic        rdLowStb,
  input  logic        rdHighStb,
  input  logic        irqClear,
  output logic        lockState,
  output ctlStrobes_t strobes
);
  logic lockNext;

  // The high read finishes a pair, so it wins when both strobes come together.
  always_comb begin
    lockNext = lockState;
    if (rdLowStb)  lockNext = 1'b1;
    if (rdHighStb) lockNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockState <= 1'b0;
    else       lockState <= lockNext;
  end

  // A low read in this cycle already forbids capture: software has just
  // sampled the old low byte.
  always_comb begin
    strobes.capture = convDone & ~lockState & ~rdLowStb;
    strobes.setFlag = convDone;
    strobes.clrFlag = irqClear;
  end
endmodule

// File: rtl/adc_lock_dp.sv
module adc_lock_dp
  import adc_lock_pkg::*;
#(
  parameter int unsigned RES_W  = DEF_RES_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [RES_W-1:0]  convData,
  input  logic              leftAdjust,
  input  logic              irqEnable,
  output logic [BYTE_W-1:0] lowData,
  output logic [BYTE_W-1:0] highData,
  output logic              irqReq,
  output logic [RES_W-1:0]  storedRaw,
  output logic              irqFlag
);
  localparam int unsigned HI_BITS = RES_W - BYTE_W;
  localparam int unsigned PAD_W   = BYTE_W - HI_BITS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                storedRaw <= '0;
    else if (strobes.capture) storedRaw <= convData;
  end

  // Set has priority so that no completion is lost.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                irqFlag <= 1'b0;
    else if (strobes.setFlag) irqFlag <= 1'b1;
    else if (strobes.clrFlag) irqFlag <= 1'b0;
  end

  logic [BYTE_W-1:0] rightLow, rightHigh, leftLow, leftHigh;

  always_comb begin
    rightLow  = storedRaw[BYTE_W-1:0];
    rightHigh = {{PAD_W{1'b0}}, storedRaw[RES_W-1:BYTE_W]};
    leftHigh  = storedRaw[RES_W-1 -: BYTE_W];
    leftLow   = {storedRaw[HI_BITS-1:0], {PAD_W{1'b0}}};
  end

  assign lowData  = leftAdjust ? leftLow  : rightLow;
  assign highData = leftAdjust ? leftHigh : rightHigh;
  assign irqReq   = irqFlag & irqEnable;
endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock
  import adc_lock_pkg::*;
#(
  parameter int unsigned RES_W  = DEF_RES_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convData,
  input  logic              rdLowStb,
  input  logic              rdHighStb,
  input  logic              leftAdjust,
  input  logic              irqEnable,
  input  logic              irqClear,
  output logic [BYTE_W-1:0] lowData,
  output logic [BYTE_W-1:0] highData,
  output logic              irqReq
);
  ctlStrobes_t      strobes;
  logic             lockState;
  logic             irqFlag;
  logic [RES_W-1:0] storedRaw;

  adc_lock_ctl i_ctl (
    .clk(clk), .rstN(rstN), .convDone(convDone), .rdLowStb(rdLowStb),
    .rdHighStb(rdHighStb), .irqClear(irqClear),
    .lockState(lockState), .strobes(strobes)
  );

  adc_lock_dp #(.RES_W(RES_W), .BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .convData(convData),
    .leftAdjust(leftAdjust), .irqEnable(irqEnable),
    .lowData(lowData), .highData(highData), .irqReq(irqReq),
    .storedRaw(storedRaw), .irqFlag(irqFlag)
  );
endmodule

// File: rtl/adc_result_lock_chk.sv
module adc_result_lock_chk #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              convDone,
  input logic [RES_W-1:0]  convData,
  input logic              rdLowStb,
  input logic              rdHighStb,
  input logic              leftAdjust,
  input logic              irqEnable,
  input logic              irqClear,
  input logic [BYTE_W-1:0] lowData,
  input logic [BYTE_W-1:0] highData,
  input logic              irqReq,
  input logic              lockState,
  input logic              irqFlag,
  input logic [RES_W-1:0]  storedRaw
);
  localparam int unsigned HI_BITS = RES_W - BYTE_W;
  localparam int unsigned PAD_W   = BYTE_W - HI_BITS;

  AST_CAPTURE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !lockState && !rdLowStb) |=> storedRaw == $past(convData)); // R1

  AST_RIGHT_PAD: assert property (@(posedge clk) disable iff (!rstN)
    !leftAdjust |-> highData[BYTE_W-1:HI_BITS] == '0); // R2

  AST_LEFT_PAD: assert property (@(posedge clk) disable iff (!rstN)
    leftAdjust |-> lowData[PAD_W-1:0] == '0); // R3

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (lockState || rdLowStb) |=> $stable(storedRaw)); // R4

  AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rdLowStb && !rdHighStb) |=> lockState); // R4

  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    rdHighStb |=> !lockState); // R5

  AST_LOCK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!lockState && !rdLowStb) |=> !lockState); // R6

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> irqFlag); // R7

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !convDone) |=> !irqFlag); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irqReq); // R9
endmodule

bind adc_result_lock adc_result_lock_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) i_chk (
  .clk(clk), .rstN(rstN), .convDone(convDone), .convData(convData),
  .rdLowStb(rdLowStb), .rdHighStb(rdHighStb), .leftAdjust(leftAdjust),
  .irqEnable(irqEnable), .irqClear(irqClear), .lowData(lowData),
  .highData(highData), .irqReq(irqReq), .lockState(lockState),
  .irqFlag(irqFlag), .storedRaw(storedRaw)
);

// File: tb/test_adc_result_lock.sv
module test_adc_result_lock;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 5000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       convDone = 1'b0;
  logic [9:0] convData = '0;
  logic       rdLowStb = 1'b0;
  logic       rdHighStb = 1'b0;
  logic       leftAdjust = 1'b0;
  logic       irqEnable = 1'b0;
  logic       irqClear = 1'b0;
  logic [7:0] lowData, highData;
  logic       irqReq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_lock i_adc_result_lock (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convData(convData),
    .rdLowStb(rdLowStb), .rdHighStb(rdHighStb), .leftAdjust(leftAdjust),
    .irqEnable(irqEnable), .irqClear(irqClear),
    .lowData(lowData), .highData(highData), .irqReq(irqReq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkBytes(input string tag, input int expHigh, input int expLow);
    check({tag, " high"}, highData, expHigh);
    check({tag, " low"}, lowData, expLow);
  endtask

  // Raise the chosen strobes for one cycle, starting at a falling edge.
  task automatic pulse(input bit done, input logic [9:0] data, input bit rdL,
                       input bit rdH, input bit clr);
    convDone = done; convData = data; rdLowStb = rdL; rdHighStb = rdH; irqClear = clr;
    @(negedge clk);
    convDone = 1'b0; rdLowStb = 1'b0; rdHighStb = 1'b0; irqClear = 1'b0;
  endtask

  task automatic tReset();
    irqEnable = 1'b1;
    #1;
    checkBytes("R10 reset", 8'h00, 8'h00);
    check("R10 reset irq", irqReq, 0);
  endtask

  task automatic tRightAdjust();
    leftAdjust = 1'b0;
    pulse(1, 10'h2A5, 0, 0, 0);
    checkBytes("R1 R2 right 2A5", 8'h02, 8'hA5);
    pulse(1, 10'h1FF, 0, 0, 0);
    checkBytes("R1 R2 right 1FF", 8'h01, 8'hFF);
    pulse(1, 10'h2A5, 0, 0, 1);
    checkBytes("R2 back to 2A5", 8'h02, 8'hA5);
  endtask

  task automatic tLeftAdjust();
    leftAdjust = 1'b1;
    #1;
    checkBytes("R3 left 2A5", 8'hA9, 8'h40);
    leftAdjust = 1'b0;
    #1;
    checkBytes("R3 back right", 8'h02, 8'hA5);
  endtask

  task automatic tLock();
    pulse(0, '0, 1, 0, 0);
    pulse(1, 10'h155, 0, 0, 0);
    checkBytes("R4 locked drop", 8'h02, 8'hA5);
    check("R7 irq on dropped", irqReq, 1);
    pulse(1, 10'h0F0, 0, 1, 0);
    checkBytes("R5 drop with high read", 8'h02, 8'hA5);
    pulse(1, 10'h133, 0, 0, 0);
    checkBytes("R5 capture after release", 8'h01, 8'h33);
    pulse(1, 10'h3AA, 1, 0, 0);
    checkBytes("R4 same-cycle low read drop", 8'h01, 8'h33);
    pulse(0, '0, 0, 1, 0);
  endtask

  task automatic tHighOnly();
    pulse(0, '0, 0, 1, 0);
    pulse(1, 10'h3C7, 0, 0, 0);
    checkBytes("R6 high-only no lock", 8'h03, 8'hC7);
  endtask

  task automatic tIrq();
    pulse(0, '0, 0, 0, 1);
    check("R8 clear", irqReq, 0);
    irqEnable = 1'b0;
    pulse(1, 10'h001, 0, 0, 0);
    check("R9 masked", irqReq, 0);
    repeat (3) @(negedge clk);
    irqEnable = 1'b1;
    #1;
    check("R9 R7 pending flag shown", irqReq, 1);
    pulse(1, 10'h002, 0, 0, 1);
    check("R8 set wins over clear", irqReq, 1);
    pulse(0, '0, 0, 0, 1);
    check("R8 clear after set", irqReq, 0);
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRightAdjust();
    tLeftAdjust();
    tLock();
    tHighOnly();
    tIrq();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule